// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends 8-bit or 9-bit words on one serial data line. It runs in slave mode, so an external master supplies the shift clock. The block never makes a clock of its own. On the host side there is a valid/ready write port into a holding stage and a second stage, the shifter, that drives the line. A word written while the shifter is idle goes straight into the shifter. A word written while another word is shifting waits in the holding stage, and the port stays not-ready until that word can move on.

The external clock is brought into the system clock domain through two flops. The block then looks for its falling edges. The line changes one bit per falling edge, least significant bit first, so the master can sample it on the rising edge. The transmitter works only while the port enable and the transmit enable are both high and the clock-source select chooses the external clock. Dropping any of these three aborts the transfer and empties both stages.

Back-pressure rules: a write happens in any cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` is high whenever the holding stage is empty. While the transmitter is inactive, writes are still taken but are thrown away. The host must keep `wr_data` and `ninth_bit` stable while `wr_valid` is high and `wr_ready` is low.

Top module: `sync_slave_tx`

## Requirements
- R1: After reset, `wr_ready` = 1, `sr_empty` = 1 and `ser_data` = 1 (idle high), and `irq` = 0 while `irq_en` = 0.
- R2: A write taken while the transmitter is active and the shifter is idle loads the shifter at that clock edge. From the next cycle, `ser_data` shows bit 0 of the word, `sr_empty` = 0 and `wr_ready` stays 1.
- R3: A write taken while a word is still shifting is held in the holding stage, and `wr_ready` reads 0 until that held word moves into the shifter.
- R4: Bits leave least significant bit first. Each falling edge of `ser_clk` moves the line to the next bit. The line updates on the third rising edge of `clk` after the falling edge and does not change in between.
- R5: When the falling edge after the last bit of the current word arrives, a held word moves into the shifter one cycle later. Its bit 0 appears on the line and `wr_ready` returns to 1.
- R6: `irq` is 1 exactly when `irq_en` = 1 and `wr_ready` = 1.
- R7: A word written with `nine_bit_mode` = 1 sends `ninth_bit` as a ninth bit after bit 7. With `nine_bit_mode` = 0, exactly 8 bits are sent. The mode and the ninth bit are captured with each write.
- R8: The transmitter is active only while `port_en`, `tx_en` and `ext_clk_sel` are all 1. A write taken while the transmitter is inactive is discarded: `ser_data` stays 1 and `sr_empty` stays 1.
- R9: When the transmitter becomes inactive, the next cycle shows `ser_data` = 1, `sr_empty` = 1 and `wr_ready` = 1. Any word that was shifting or held is lost.
- R10: After the falling edge that ends the last bit, with no word held, the line returns to 1 and `sr_empty` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| ext_clk_sel | input | 1 | Clock source select; 1 = external clock (slave) |
| nine_bit_mode | input | 1 | Send 9 bits with the word being written |
| ninth_bit | input | 1 | Ninth data bit for the word being written |
| irq_en | input | 1 | Interrupt enable |
| wr_valid | input | 1 | Host offers a word |
| wr_data | input | DATA_W | Word to send |
| wr_ready | output | 1 | Holding stage can take a word (ready flag) |
| irq | output | 1 | Interrupt request |
| sr_empty | output | 1 | No word shifting and none held |
| ser_clk | input | 1 | External shift clock from the master |
| ser_data | output | 1 | Serial data line, idle high |

## Verification
Port results are due one cycle after the edge that accepts a write or drops an enable. Line results are due three system cycles after a falling edge of `ser_clk`. A word waiting in the holding stage reaches the line one cycle after that. The bench changes all inputs on the falling edge of `clk` and holds each half of the external clock for five system cycles. It samples each bit just before the next rising edge of `ser_clk`, so every check falls after its result is due and before the next change. Port checks that follow a write or an enable change are sampled at the next falling edge of `clk`.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    PH_IDLE  = 1'b0,
    PH_SHIFT = 1'b1
  } tx_phase_e;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync
  import sst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic fall
);
  logic [SYNC_STAGES-1:0] stages;
  logic                   last_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stages   <= '0;
      last_lvl <= 1'b0;
    end else begin
      stages   <= {stages[SYNC_STAGES-2:0], ext_clk};
      last_lvl <= stages[SYNC_STAGES-1];
    end
  end

  assign fall = last_lvl && !stages[SYNC_STAGES-1];

  // R4: one external falling edge yields a single-cycle pulse
  a_r4_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [DATA_W:0] load_frame,
  input  logic            load_nine,
  input  logic            tick,
  output logic            busy,
  output logic            sdo
);
  localparam int unsigned FW = DATA_W + 1;
  localparam int unsigned CW = $clog2(FW + 1);

  tx_phase_e      phase;
  logic [FW-1:0]  sreg;
  logic [CW-1:0]  left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      sreg  <= '1;
      left  <= '0;
      sdo   <= 1'b1;
    end else if (clr) begin
      phase <= PH_IDLE;
      sreg  <= '1;
      left  <= '0;
      sdo   <= 1'b1;
    end else if (load) begin
      phase <= PH_SHIFT;
      sreg  <= load_frame;
      sdo   <= load_frame[0];
      left  <= load_nine ? CW'(DATA_W) : CW'(DATA_W - 1);
    end else if (tick && phase == PH_SHIFT) begin
      if (left == '0) begin
        phase <= PH_IDLE;
        sdo   <= 1'b1;
        sreg  <= '1;
      end else begin
        sreg  <= {1'b1, sreg[FW-1:1]};
        sdo   <= sreg[1];
        left  <= left - 1'b1;
      end
    end
  end

  assign busy = (phase == PH_SHIFT);

  // R4: the line only moves on a shift tick, a load or a clear
  a_r4_line_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !clr) |=> $stable(sdo));
  // R10: an idle shifter keeps the line high
  a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> sdo);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sst_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              ext_clk_sel,
  input  logic              nine_bit_mode,
  input  logic              ninth_bit,
  input  logic              irq_en,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              irq,
  output logic              sr_empty,
  input  logic              ser_clk,
  output logic              ser_data
);
  logic              active;
  logic              accept;
  logic              fall;
  logic              sh_busy;
  logic              sh_load;
  logic [DATA_W:0]   sh_frame;
  logic              sh_nine;
  logic              hold_valid;
  logic [DATA_W:0]   hold_frame;
  logic              hold_nine;
  logic              from_hold;

  assign active = port_en && tx_en && ext_clk_sel;
  assign accept = wr_valid && wr_ready && active;

  sst_clk_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_clk (ser_clk),
    .fall    (fall)
  );

  assign from_hold = hold_valid && !sh_busy;

  always_comb begin
    sh_load  = 1'b0;
    sh_frame = {ninth_bit, wr_data};
    sh_nine  = nine_bit_mode;
    if (from_hold) begin
      sh_load  = 1'b1;
      sh_frame = hold_frame;
      sh_nine  = hold_nine;
    end else if (accept && !sh_busy) begin
      sh_load  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      hold_frame <= '0;
      hold_nine  <= 1'b0;
    end else if (!active) begin
      hold_valid <= 1'b0;
    end else if (from_hold) begin
      hold_valid <= 1'b0;
    end else if (accept && sh_busy) begin
      hold_valid <= 1'b1;
      hold_frame <= {ninth_bit, wr_data};
      hold_nine  <= nine_bit_mode;
    end
  end

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!active),
    .load       (sh_load && active),
    .load_frame (sh_frame),
    .load_nine  (sh_nine),
    .tick       (fall),
    .busy       (sh_busy),
    .sdo        (ser_data)
  );

  assign wr_ready = !hold_valid;
  assign sr_empty = !sh_busy && !hold_valid;
  assign irq      = irq_en && wr_ready;

  // R2: a write to an idle shifter goes straight in, port stays ready
  a_r2_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sh_busy) |=> (sh_busy && wr_ready));
  // R3: a write behind a shifting word blocks the port
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sh_busy) |=> !wr_ready);
  // R9: going inactive clears everything next cycle
  a_r9_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (ser_data && sr_empty && wr_ready));
  // R6: no interrupt while the port is blocked
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> !irq);
endmodule

// File: tb/tb_sync_slave_tx.sv
`timescale 1ns/1ps
module tb_sync_slave_tx;
  localparam int DATA_W = 8;
  localparam int HALF   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_en = 1'b0, tx_en = 1'b0, ext_clk_sel = 1'b0;
  logic nine_bit_mode = 1'b0, ninth_bit = 1'b0, irq_en = 1'b0;
  logic wr_valid = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic wr_ready, irq, sr_empty, ser_data;
  logic ser_clk = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_slave_tx #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_en(tx_en),
    .ext_clk_sel(ext_clk_sel), .nine_bit_mode(nine_bit_mode),
    .ninth_bit(ninth_bit), .irq_en(irq_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .irq(irq),
    .sr_empty(sr_empty), .ser_clk(ser_clk), .ser_data(ser_data)
  );

  function automatic logic exp_bit(input logic [7:0] d, input logic b9, input int i);
    return (i < 8) ? d[i] : b9;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic write(input logic [7:0] d, input logic nine, input logic b9);
    wr_data = d; nine_bit_mode = nine; ninth_bit = b9; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse();
    ser_clk = 1'b1;
    repeat (HALF) @(negedge clk);
    ser_clk = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  // R4 R7: check each bit, LSB first, then clock it out
  task automatic send_word(input logic [7:0] d, input logic nine, input logic b9);
    int n;
    n = nine ? 9 : 8;
    for (int i = 0; i < n; i++) begin
      check(nine && i == 8 ? "R7" : "R4", ser_data, exp_bit(d, b9, i));
      pulse();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [7:0] a, b;
    logic na, nb, ba, bb, two;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", wr_ready, 1'b1);
    check("R1", sr_empty, 1'b1);
    check("R1", ser_data, 1'b1);
    check("R1", irq, 1'b0);

    port_en = 1; tx_en = 1; ext_clk_sel = 1; irq_en = 1;
    @(negedge clk);
    check("R6", irq, 1'b1);

    // R2 single word, R10 return to idle
    write(8'hA5, 1'b0, 1'b0);
    check("R2", wr_ready, 1'b1);
    check("R2", sr_empty, 1'b0);
    send_word(8'hA5, 1'b0, 1'b0);
    check("R10", ser_data, 1'b1);
    check("R10", sr_empty, 1'b1);

    // R3 R5 R7 back-to-back, second with ninth bit
    write(8'h3C, 1'b0, 1'b0);
    write(8'h81, 1'b1, 1'b1);
    check("R3", wr_ready, 1'b0);
    check("R6", irq, 1'b0);
    send_word(8'h3C, 1'b0, 1'b0);
    check("R5", wr_ready, 1'b1);
    check("R5", sr_empty, 1'b0);
    send_word(8'h81, 1'b1, 1'b1);
    check("R10", sr_empty, 1'b1);

    // R7 nine-bit with ninth bit 0
    write(8'hFF, 1'b1, 1'b0);
    send_word(8'hFF, 1'b1, 1'b0);
    check("R10", ser_data, 1'b1);

    // R8 writes dropped while inactive, for each enable
    for (int k = 0; k < 3; k++) begin
      port_en = (k != 0); tx_en = (k != 1); ext_clk_sel = (k != 2);
      @(negedge clk);
      write(8'h00, 1'b0, 1'b0);
      check("R8", ser_data, 1'b1);
      check("R8", sr_empty, 1'b1);
      pulse();
      check("R8", ser_data, 1'b1);
    end
    port_en = 1; tx_en = 1; ext_clk_sel = 1;
    @(negedge clk);

    // R9 abort mid-word with a held word
    write(8'h00, 1'b0, 1'b0);
    write(8'h55, 1'b0, 1'b0);
    pulse(); pulse();
    check("R9", ser_data, 1'b0);
    tx_en = 1'b0;
    @(negedge clk);
    check("R9", ser_data, 1'b1);
    check("R9", sr_empty, 1'b1);
    check("R9", wr_ready, 1'b1);
    tx_en = 1'b1;
    pulse();
    check("R9", ser_data, 1'b1);
    irq_en = 1'b0;
    @(negedge clk);
    check("R6", irq, 1'b0);
    irq_en = 1'b1;

    // random words, single or back-to-back
    for (int it = 0; it < 40; it++) begin
      a = 8'($urandom); b = 8'($urandom);
      na = 1'($urandom); nb = 1'($urandom);
      ba = 1'($urandom); bb = 1'($urandom);
      two = 1'($urandom);
      write(a, na, ba);
      check("R2", wr_ready, 1'b1);
      if (two) begin
        write(b, nb, bb);
        check("R3", wr_ready, 1'b0);
      end
      send_word(a, na, ba);
      if (two) begin
        check("R5", wr_ready, 1'b1);
        check("R6", irq, 1'b1);
        send_word(b, nb, bb);
      end
      check("R10", ser_data, 1'b1);
      check("R10", sr_empty, 1'b1);
    end

    finished = 1;
    summary();
  end
endmodule